// File: doc/BRIEF.md
# Indirect-Indexed Host Register Port

This block is the byte-wide host-side register front end of a peripheral. A host reaches it through four direct locations picked by a 2-bit address. One location holds an index. A second location is a window onto sixteen byte-wide indirect registers, and the index picks which of them the window reaches. The third location is a status byte, and the fourth is a data location that goes to a playback register on writes and to a capture register on reads. The core logic sees every indirect register, the playback byte and the status byte as plain outputs.

The status byte has one sticky bit, the interrupt flag in bit 0. It is raised by a core event pulse and stays set until the host writes the status location. Bits 7:1 are a snapshot of core state, refreshed on every sample-period tick. The capture byte is refreshed on the same tick. Reads are combinational while the read strobe is high. Writes land on the clock edge that samples the write strobe.

Top module: `hreg_port`

## Requirements
- R1: After reset, the index register, all sixteen indirect registers, the playback register, the capture register and the whole status byte read as zero.
- R2: A write to address 0 stores all 8 data bits in the index register. A read at address 0 returns those 8 bits unchanged.
- R3: A write to address 1 updates only the indirect register numbered by index bits 3:0. A read at address 1 returns that register. Indirect register k appears on `ind_regs[8k+7:8k]`.
- R4: Index bits 7:4 have no effect on which indirect register address 1 reaches.
- R5: A write to address 3 updates the playback register seen on `play_data`. A read at address 3 returns the capture register and never the playback register.
- R6: The capture register loads `core_cap_in` on a cycle with `core_tick` high and holds its value otherwise.
- R7: Status bits 7:1 load `core_stat_in` on a cycle with `core_tick` high and hold their value otherwise. A read at address 2 returns {bits 7:1, interrupt flag}.
- R8: A cycle with `core_irq_evt` high sets the interrupt flag from the next cycle on. The flag then stays set until it is cleared as in R9.
- R9: Any write to address 2 clears the interrupt flag, whatever the data. If an interrupt event arrives in the same cycle, the flag stays set. Such a write leaves status bits 7:1 unchanged.
- R10: `host_rdata` is zero whenever `host_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 2 | Direct location select (0 index, 1 window, 2 status, 3 data) |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Write strobe, sampled on the clock edge |
| host_rd | input | 1 | Read strobe, read data valid while high |
| host_rdata | output | 8 | Read data, combinational |
| core_tick | input | 1 | Sample-period pulse |
| core_stat_in | input | 7 | Live core status for status bits 7:1 |
| core_cap_in | input | 8 | Core capture byte |
| core_irq_evt | input | 1 | Interrupt event pulse |
| play_data | output | 8 | Playback register contents |
| status_byte | output | 8 | Status register contents |
| ind_regs | output | 128 | All indirect registers, register k in bits 8k+7:8k |

## Verification
Reads are combinational, so a read is checked in the same cycle, 1 ns after the inputs change on the falling edge, and it is compared against the model state from before the next rising edge. A write, a tick or an event takes effect one cycle later: it changes state on the rising edge that samples it, and it is checked at the next falling edge. The bench model updates only after that rising edge, so the two stay in step. The directed cases cover a clear and an event in the same cycle, index values with the upper bits set, and the difference between the two data registers at address 3.

// File: rtl/hreg_pkg.sv
package hreg_pkg;
  // direct location codes on the 2-bit host address
  typedef enum logic [1:0] {
    LOC_INDEX  = 2'd0,
    LOC_WINDOW = 2'd1,
    LOC_STATUS = 2'd2,
    LOC_DATA   = 2'd3
  } hloc_e;
endpackage

// File: rtl/hreg_index.sv
module hreg_index #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] idx_q
);
  logic [DW-1:0] idx_d;

  always_comb begin
    idx_d = idx_q;
    if (we) idx_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(idx_q)); // R2
  AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> idx_q == $past(wdata)); // R2
endmodule

// File: rtl/hreg_bank.sv
module hreg_bank #(
  parameter int DW   = 8,
  parameter int IDXW = 4,
  localparam int NREG = 1 << IDXW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [IDXW-1:0]    sel,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      rdata,
  output logic [NREG*DW-1:0] flat
);
  logic [DW-1:0]   reg_q [NREG];
  logic [NREG-1:0] wr_vec;

  // one-hot write decode from the low index bits
  always_comb begin
    wr_vec = '0;
    if (we) wr_vec[sel] = 1'b1;
  end

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    logic [DW-1:0] reg_d;

    always_comb begin
      reg_d = reg_q[k];
      if (wr_vec[k]) reg_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reg_q[k] <= '0;
      else        reg_q[k] <= reg_d;
    end

    assign flat[k*DW +: DW] = reg_q[k];

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_vec[k] |=> $stable(reg_q[k])); // R3
  end

  assign rdata = reg_q[sel];

  AST_BANK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_vec)); // R3
endmodule

// File: rtl/hreg_status.sv
module hreg_status #(
  parameter int DW = 8,
  localparam int SW = DW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          evt,
  input  logic          tick,
  input  logic [SW-1:0] stat_in,
  output logic [DW-1:0] status_q
);
  logic          irq_q, irq_d;
  logic [SW-1:0] snap_q, snap_d;

  // the event wins over a clear in the same cycle
  always_comb begin
    irq_d = irq_q;
    if (clr) irq_d = 1'b0;
    if (evt) irq_d = 1'b1;
  end

  always_comb begin
    snap_d = snap_q;
    if (tick) snap_d = stat_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      snap_q <= '0;
    end else begin
      irq_q  <= irq_d;
      snap_q <= snap_d;
    end
  end

  assign status_q = {snap_q, irq_q};

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !clr |=> irq_q); // R8
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> irq_q); // R9
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !evt |=> !irq_q); // R9
  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(snap_q)); // R7
endmodule

// File: rtl/hreg_xfer.sv
module hreg_xfer #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          play_we,
  input  logic [DW-1:0] wdata,
  input  logic          tick,
  input  logic [DW-1:0] cap_in,
  output logic [DW-1:0] play_q,
  output logic [DW-1:0] cap_q
);
  logic [DW-1:0] play_d, cap_d;

  always_comb begin
    play_d = play_q;
    if (play_we) play_d = wdata;
    cap_d = cap_q;
    if (tick) cap_d = cap_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      play_q <= '0;
      cap_q  <= '0;
    end else begin
      play_q <= play_d;
      cap_q  <= cap_d;
    end
  end

  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cap_q)); // R6
  AST_PLAY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !play_we |=> $stable(play_q)); // R5
endmodule

// File: rtl/hreg_port.sv
module hreg_port #(
  parameter int DW   = 8,
  parameter int IDXW = 4,
  localparam int NREG = 1 << IDXW,
  localparam int SW   = DW - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         host_addr,
  input  logic [DW-1:0]      host_wdata,
  input  logic               host_wr,
  input  logic               host_rd,
  output logic [DW-1:0]      host_rdata,
  input  logic               core_tick,
  input  logic [SW-1:0]      core_stat_in,
  input  logic [DW-1:0]      core_cap_in,
  input  logic               core_irq_evt,
  output logic [DW-1:0]      play_data,
  output logic [DW-1:0]      status_byte,
  output logic [NREG*DW-1:0] ind_regs
);
  import hreg_pkg::*;

  hloc_e         loc;
  logic          we_index, we_window, we_status, we_data;
  logic [DW-1:0] idx_q, win_rdata, cap_q;

  assign loc = hloc_e'(host_addr);

  // direct write decode
  always_comb begin
    we_index  = host_wr && (loc == LOC_INDEX);
    we_window = host_wr && (loc == LOC_WINDOW);
    we_status = host_wr && (loc == LOC_STATUS);
    we_data   = host_wr && (loc == LOC_DATA);
  end

  hreg_index #(.DW(DW)) u_index (
    .clk(clk), .rst_n(rst_n), .we(we_index), .wdata(host_wdata), .idx_q(idx_q)
  );

  hreg_bank #(.DW(DW), .IDXW(IDXW)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(we_window), .sel(idx_q[IDXW-1:0]),
    .wdata(host_wdata), .rdata(win_rdata), .flat(ind_regs)
  );

  hreg_status #(.DW(DW)) u_status (
    .clk(clk), .rst_n(rst_n), .clr(we_status), .evt(core_irq_evt),
    .tick(core_tick), .stat_in(core_stat_in), .status_q(status_byte)
  );

  hreg_xfer #(.DW(DW)) u_xfer (
    .clk(clk), .rst_n(rst_n), .play_we(we_data), .wdata(host_wdata),
    .tick(core_tick), .cap_in(core_cap_in), .play_q(play_data), .cap_q(cap_q)
  );

  // combinational read path, quiet while no read strobe
  always_comb begin
    host_rdata = '0;
    if (host_rd) begin
      unique case (loc)
        LOC_INDEX:  host_rdata = idx_q;
        LOC_WINDOW: host_rdata = win_rdata;
        LOC_STATUS: host_rdata = status_byte;
        LOC_DATA:   host_rdata = cap_q;
        default:    host_rdata = '0;
      endcase
    end
  end

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |-> host_rdata == '0); // R10
  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({we_index, we_window, we_status, we_data}) <= 1); // R3
  AST_DATA_READ_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && loc == LOC_DATA |-> host_rdata == cap_q); // R5
endmodule

// File: tb/tb_hreg_port.sv
`timescale 1ns/1ps
module tb_hreg_port;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   host_addr;
  logic [7:0]   host_wdata;
  logic         host_wr, host_rd;
  logic [7:0]   host_rdata;
  logic         core_tick;
  logic [6:0]   core_stat_in;
  logic [7:0]   core_cap_in;
  logic         core_irq_evt;
  logic [7:0]   play_data, status_byte;
  logic [127:0] ind_regs;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference model state
  logic [7:0] m_idx, m_play, m_cap;
  logic [7:0] m_reg [16];
  logic [6:0] m_snap;
  logic       m_irq;

  always #2.5 clk = ~clk;

  hreg_port dut (.*);

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] exp_flat();
    logic [127:0] f;
    for (int k = 0; k < 16; k++) f[k*8 +: 8] = m_reg[k];
    return f;
  endfunction

  function automatic logic [7:0] exp_read(logic [1:0] a);
    case (a)
      2'd0: return m_idx;
      2'd1: return m_reg[m_idx[3:0]];
      2'd2: return {m_snap, m_irq};
      default: return m_cap;
    endcase
  endfunction

  function automatic string read_tag(logic [1:0] a);
    case (a)
      2'd0: return "R2";
      2'd1: return (m_idx[7:4] != 0) ? "R4" : "R3";
      2'd2: return "R7";
      default: return "R5";
    endcase
  endfunction

  // one clock cycle: drive at negedge, check reads 1 ns later, update model after posedge
  task automatic cyc(bit wr, bit rd, logic [1:0] a, logic [7:0] d,
                     bit evt, bit tick, logic [6:0] st, logic [7:0] cp);
    @(negedge clk);
    host_wr = wr; host_rd = rd; host_addr = a; host_wdata = d;
    core_irq_evt = evt; core_tick = tick; core_stat_in = st; core_cap_in = cp;
    #1;
    chk("R3 ind_regs", ind_regs, exp_flat());
    chk("R5 play_data", {120'd0, play_data}, {120'd0, m_play});
    if (rd) chk(read_tag(a), {120'd0, host_rdata}, {120'd0, exp_read(a)});
    else    chk("R10 idle rdata", {120'd0, host_rdata}, 128'd0);
    @(posedge clk);
    if (wr) begin
      case (a)
        2'd0: m_idx = d;
        2'd1: m_reg[m_idx[3:0]] = d;
        2'd2: m_irq = 1'b0;
        default: m_play = d;
      endcase
    end
    if (evt) m_irq = 1'b1;
    if (tick) begin m_snap = st; m_cap = cp; end
  endtask

  task automatic idle();
    cyc(0, 0, 2'd0, 8'd0, 0, 0, 7'd0, 8'd0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1846));
    rst_n = 1'b0;
    host_wr = 0; host_rd = 0; host_addr = 0; host_wdata = 0;
    core_irq_evt = 0; core_tick = 0; core_stat_in = 0; core_cap_in = 0;
    m_idx = 0; m_play = 0; m_cap = 0; m_snap = 0; m_irq = 0;
    for (int k = 0; k < 16; k++) m_reg[k] = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, read every direct location
    for (int a = 0; a < 4; a++) begin
      @(negedge clk);
      host_rd = 1; host_addr = 2'(a);
      #1 chk("R1 reset read", {120'd0, host_rdata}, 128'd0);
    end
    host_rd = 0;
    chk("R1 reset ind_regs", ind_regs, 128'd0);
    chk("R1 reset status", {120'd0, status_byte}, 128'd0);

    // R2: full byte index readback
    cyc(1, 0, 2'd0, 8'hA5, 0, 0, 0, 0);
    cyc(0, 1, 2'd0, 8'h00, 0, 0, 0, 0);
    // R3/R4: upper index bits do not change the decode
    cyc(1, 0, 2'd1, 8'h3C, 0, 0, 0, 0);   // lands in reg 5
    cyc(1, 0, 2'd0, 8'h05, 0, 0, 0, 0);
    cyc(0, 1, 2'd1, 8'h00, 0, 0, 0, 0);   // R3 reads 3C from reg 5
    cyc(1, 0, 2'd0, 8'hF5, 0, 0, 0, 0);
    cyc(0, 1, 2'd1, 8'h00, 0, 0, 0, 0);   // R4 same reg 5
    // R5: playback vs capture at address 3
    cyc(1, 0, 2'd3, 8'h77, 0, 0, 0, 0);
    cyc(0, 1, 2'd3, 8'h00, 0, 0, 0, 0);   // reads capture (0), not 77
    // R6/R7: tick loads snapshot and capture
    cyc(0, 0, 2'd0, 8'h00, 0, 1, 7'h55, 8'h9E);
    cyc(0, 1, 2'd3, 8'h00, 0, 0, 7'h11, 8'h22);
    cyc(0, 1, 2'd2, 8'h00, 0, 0, 7'h11, 8'h22);
    chk("R7 status_byte", {120'd0, status_byte}, {120'd0, m_snap, m_irq});
    // R8: sticky flag
    cyc(0, 0, 2'd0, 8'h00, 1, 0, 0, 0);
    idle(); idle();
    cyc(0, 1, 2'd2, 8'h00, 0, 0, 0, 0);
    chk("R8 irq sticky", {127'd0, status_byte[0]}, 128'd1);
    // R9: clear, then clear colliding with event
    cyc(1, 0, 2'd2, 8'hFF, 0, 0, 0, 0);
    cyc(0, 1, 2'd2, 8'h00, 0, 0, 0, 0);
    chk("R9 irq cleared", {127'd0, status_byte[0]}, 128'd0);
    chk("R9 snap kept", {121'd0, status_byte[7:1]}, {121'd0, 7'h55});
    cyc(1, 0, 2'd2, 8'h00, 1, 0, 0, 0);
    cyc(0, 1, 2'd2, 8'h00, 0, 0, 0, 0);
    chk("R9 event wins", {127'd0, status_byte[0]}, 128'd1);

    // constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      bit wr, rd, ev, tk;
      wr = ($urandom % 3) == 0;
      rd = ($urandom % 2) == 0;
      ev = ($urandom % 7) == 0;
      tk = ($urandom % 8) == 0;
      cyc(wr, rd, 2'($urandom), 8'($urandom), ev, tk, 7'($urandom), 8'($urandom));
    end
    idle();
    chk("R7 final status", {120'd0, status_byte}, {120'd0, m_snap, m_irq});

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule